// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Controller

This block drives a common-cathode seven-segment display of up to eight digits by enabling one digit at a time and presenting that digit's segment pattern on eight shared segment lines (A to G plus the decimal point). It holds no digit storage of its own. The register file sits elsewhere and presents the eight data bytes, a per-digit decode mask, a 4-bit brightness code, a 3-bit scan length, a shutdown flag and a lamp-test flag as steady inputs.

A free-running prescaler divides the system clock into PWM ticks, and 32 ticks make one digit slot. Inside a slot the segments light for the first 2k+1 ticks, where k is the brightness code, and stay dark for the rest. The last tick of every slot is always dark, so the segment lines are quiet when the digit select moves on. Each digit is either shown through a built-in numeric font or passed through as raw segment bits. With the default divider chosen to match, a full eight-digit frame repeats at roughly 800 Hz.

Top module: `seg_scan_ctrl`

## Requirements
- R1: While rst_n is low, seg_out is 0x00 and dig_sel_n is 0xFF. The first slot after reset selects digit 0.
- R2: A slot lasts 32*TICK_DIV clocks. In each slot exactly one dig_sel_n bit is low. The digits visited are 0,1,...,N and then 0 again, where N = scan_limit (0 to 7). A lower scan_limit takes effect at the next slot boundary.
- R3: For brightness code k (0 to 15), the segments show their pattern for the first (2k+1)*TICK_DIV clocks of the slot and are 0x00 for the rest. A code of 15 therefore gives 31/32 of the slot.
- R4: When decode_mask bit i is 1, the low nibble of digit i selects a glyph. Segment bits are ordered A..G = seg_out[6:0]. The glyphs are: 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B, A (dash)=01, B (E)=4F, C (H)=37, D (L)=0E, E (P)=67, F (blank)=00. Bits 6:4 of the byte are ignored.
- R5: seg_out[7] (decimal point) equals bit 7 of the selected digit byte in both decoded and raw modes.
- R6: When decode_mask bit i is 0, the byte drives the segments directly: bit 7 to DP (seg_out[7]), bit 6 to A, bit 5 to B, bit 4 to C, bit 3 to D, bit 2 to E, bit 1 to F and bit 0 to G (seg_out[0]).
- R7: While shutdown is 1 and test_mode is 0, seg_out is 0x00 and dig_sel_n is 0xFF. The digit data is kept, and it shows again once shutdown is cleared.
- R8: While test_mode is 1, every digit 0 to 7 is scanned regardless of scan_limit, and seg_out is 0xFF for the first 31*TICK_DIV clocks of each slot. This holds even while shutdown is 1. When test_mode is cleared, the earlier display returns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_data | input | 64 | Eight digit bytes; digit i at [8i+7:8i] |
| decode_mask | input | 8 | Bit i = 1 shows digit i through the font |
| intensity | input | 4 | Brightness code k; on-time (2k+1)/32 |
| scan_limit | input | 3 | Highest digit index scanned |
| shutdown | input | 1 | Blanks the display |
| test_mode | input | 1 | Lamp test; all segments on at 31/32 |
| seg_out | output | 8 | DP,A,B,C,D,E,F,G on bits 7..0; 1 = lit |
| dig_sel_n | output | 8 | Digit selects, active low |

## Verification
The bench first checks the two ends of the brightness range. A design with an off-by-one duty would light code 0 for zero or two ticks, and would either light code 15 through the whole slot or show a lit tick at the slot boundary. It lowers scan_limit while a higher digit is on. A design that compares the limit with equality instead of at-or-above would then run on to digit 7. It also checks the priority between lamp test and shutdown, and whether the lamp test forces all eight digits. A design with these wrong stays dark during the lamp test or scans only the programmed digits. It checks that the decimal point comes from bit 7 in decoded mode too, which a font lookup applied to the whole byte would lose.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int SEG_W = 8;

  // Numeric font, segments ordered A..G on bits 6..0
  function automatic logic [6:0] glyph(input logic [3:0] code);
    logic [6:0] g;
    unique case (code)
      4'h0: g = 7'h7E;
      4'h1: g = 7'h30;
      4'h2: g = 7'h6D;
      4'h3: g = 7'h79;
      4'h4: g = 7'h33;
      4'h5: g = 7'h5B;
      4'h6: g = 7'h5F;
      4'h7: g = 7'h70;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h7B;
      4'hA: g = 7'h01;
      4'hB: g = 7'h4F;
      4'hC: g = 7'h37;
      4'hD: g = 7'h0E;
      4'hE: g = 7'h67;
      default: g = 7'h00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
  parameter int TICK_DIV = 16,
  parameter int DIG_W    = 3,
  parameter int PH_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIG_W-1:0] last_digit,
  output logic [PH_W-1:0]  phase,
  output logic [DIG_W-1:0] digit,
  output logic             slot_end
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [DIG_W-1:0] dig_q, dig_d;
  logic             tick;

  always_comb begin
    tick     = (pre_q == PRE_W'(TICK_DIV - 1));
    slot_end = tick && (ph_q == '1);
    pre_d    = tick ? '0 : pre_q + PRE_W'(1);
    ph_d     = tick ? ph_q + PH_W'(1) : ph_q;
    dig_d    = dig_q;
    if (slot_end) begin
      dig_d = (dig_q >= last_digit) ? '0 : dig_q + DIG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
      dig_q <= '0;
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
      dig_q <= dig_d;
    end
  end

  assign phase = ph_q;
  assign digit = dig_q;

  // R2: a slot boundary either wraps to 0 or steps up by one
  p_digit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (dig_q == '0) || (dig_q == $past(dig_q) + DIG_W'(1)));

  // R2: after a boundary the digit never exceeds the limit
  p_digit_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (dig_q <= $past(last_digit)));

endmodule

// File: rtl/seg_scan_decode.sv
module seg_scan_decode
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DIG_W      = 3
) (
  input  logic [NUM_DIGITS*SEG_W-1:0] digit_data,
  input  logic [NUM_DIGITS-1:0]       decode_mask,
  input  logic [DIG_W-1:0]            sel,
  output logic [SEG_W-1:0]            pattern
);

  logic [SEG_W-1:0] bytes [NUM_DIGITS];
  logic [SEG_W-1:0] cur;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_bytes
    assign bytes[i] = digit_data[i*SEG_W +: SEG_W];
  end

  always_comb begin
    cur = bytes[sel];
    if (decode_mask[sel]) pattern = {cur[7], glyph(cur[3:0])};
    else                  pattern = cur;
  end

  // R5: the decimal point always follows bit 7
  always_comb begin
    a_dp_follows_r5: assert (pattern[7] == cur[7] || $isunknown(cur));
  end

endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int INT_W      = 4,
  parameter int TICK_DIV   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DIGITS*SEG_W-1:0] digit_data,
  input  logic [NUM_DIGITS-1:0]       decode_mask,
  input  logic [INT_W-1:0]            intensity,
  input  logic [$clog2(NUM_DIGITS)-1:0] scan_limit,
  input  logic                        shutdown,
  input  logic                        test_mode,
  output logic [SEG_W-1:0]            seg_out,
  output logic [NUM_DIGITS-1:0]       dig_sel_n
);

  localparam int DIG_W = $clog2(NUM_DIGITS);
  localparam int PH_W  = INT_W + 1;

  logic [PH_W-1:0]       phase;
  logic [DIG_W-1:0]      digit, last_digit;
  logic                  slot_end;
  logic [SEG_W-1:0]      pattern;
  logic [NUM_DIGITS-1:0] sel_oh;
  logic [INT_W-1:0]      level;
  logic                  dark, lit;
  logic [SEG_W-1:0]      seg_d, seg_q;
  logic [NUM_DIGITS-1:0] dig_d, dig_q;

  assign last_digit = test_mode ? DIG_W'(NUM_DIGITS - 1) : scan_limit;

  seg_scan_timer #(.TICK_DIV(TICK_DIV), .DIG_W(DIG_W), .PH_W(PH_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_digit (last_digit),
    .phase      (phase),
    .digit      (digit),
    .slot_end   (slot_end)
  );

  seg_scan_decode #(.NUM_DIGITS(NUM_DIGITS), .DIG_W(DIG_W)) u_decode (
    .digit_data  (digit_data),
    .decode_mask (decode_mask),
    .sel         (digit),
    .pattern     (pattern)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
    assign sel_oh[i] = (digit == DIG_W'(i));
  end

  always_comb begin
    dark  = shutdown && !test_mode;
    level = test_mode ? '1 : intensity;
    lit   = phase < {level, 1'b1};
    seg_d = '0;
    if (!dark && lit) seg_d = test_mode ? '1 : pattern;
    dig_d = dark ? '1 : ~sel_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      dig_q <= '1;
    end else begin
      seg_q <= seg_d;
      dig_q <= dig_d;
    end
  end

  assign seg_out   = seg_q;
  assign dig_sel_n = dig_q;

  // R2: never more than one digit selected
  p_one_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig_sel_n));

  // R3: the final tick of a slot is always dark
  p_boundary_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '1) |=> (seg_out == '0));

  // R3: the first tick of a slot shows the pattern
  p_first_tick_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0 && !shutdown && !test_mode) |=> (seg_out == $past(pattern)));

  // R7: shutdown without test blanks everything
  p_shutdown_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !test_mode) |=> (seg_out == '0 && dig_sel_n == '1));

  // R8: test mode lights all segments except on the last tick
  p_test_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && phase != '1) |=> (seg_out == '1 && dig_sel_n != '1));

endmodule

// File: tb/sim_seg_scan_ctrl.sv
`timescale 1ns/1ps
module sim_seg_scan_ctrl;

  localparam int ND   = 8;
  localparam int TD   = 2;
  localparam int SLOT = 32 * TD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [ND*8-1:0] digit_data;
  logic [ND-1:0] decode_mask;
  logic [3:0]    intensity;
  logic [2:0]    scan_limit;
  logic          shutdown, test_mode;
  logic [7:0]    seg_out;
  logic [ND-1:0] dig_sel_n;

  always #4 clk = ~clk;

  seg_scan_ctrl #(.NUM_DIGITS(ND), .INT_W(4), .TICK_DIV(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .digit_data(digit_data), .decode_mask(decode_mask),
    .intensity(intensity), .scan_limit(scan_limit), .shutdown(shutdown),
    .test_mode(test_mode), .seg_out(seg_out), .dig_sel_n(dig_sel_n)
  );

  int checks = 0;
  int errors = 0;
  int exp_dig = 0;
  logic [7:0] q_dig[$];
  logic [7:0] q_seg[$];
  int         q_on[$];
  string      q_tag[$];
  event slot_done;

  function automatic logic [6:0] ref_font(input logic [3:0] v);
    case (v)
      4'h0: return 7'h7E;  4'h1: return 7'h30;  4'h2: return 7'h6D;  4'h3: return 7'h79;
      4'h4: return 7'h33;  4'h5: return 7'h5B;  4'h6: return 7'h5F;  4'h7: return 7'h70;
      4'h8: return 7'h7F;  4'h9: return 7'h7B;  4'hA: return 7'h01;  4'hB: return 7'h4F;
      4'hC: return 7'h37;  4'hD: return 7'h0E;  4'hE: return 7'h67;  default: return 7'h00;
    endcase
  endfunction

  // Driver: push the expectation for the coming slot
  task automatic push_slot(input string tag);
    logic [7:0] b;
    int lim_eff;
    b = digit_data[exp_dig*8 +: 8];
    lim_eff = test_mode ? 7 : int'(scan_limit);
    if (shutdown && !test_mode) begin
      q_dig.push_back(8'hFF); q_seg.push_back(8'h00); q_on.push_back(0);
    end else begin
      q_dig.push_back(~(8'h01 << exp_dig));
      if (test_mode) begin
        q_seg.push_back(8'hFF); q_on.push_back(31 * TD);
      end else begin
        q_seg.push_back(decode_mask[exp_dig] ? {b[7], ref_font(b[3:0])} : b);
        q_on.push_back((2 * int'(intensity) + 1) * TD);
      end
    end
    q_tag.push_back(tag);
    exp_dig = (exp_dig >= lim_eff) ? 0 : exp_dig + 1;
  endtask

  task automatic play(input int n, input string tag);
    repeat (n) begin
      push_slot(tag);
      @(slot_done);
    end
  endtask

  // Monitor: compare every sample of a slot, one check per slot
  int idx = 0, mis = 0;
  logic [7:0] a_seg, e_seg, a_dig, e_dig;
  always @(negedge clk) begin
    if (!rst_n) begin
      idx = 0; mis = 0;
    end else begin
      if (q_seg.size() > 0) begin
        logic [7:0] es;
        es = (idx < q_on[0]) ? q_seg[0] : 8'h00;
        if (seg_out !== es || dig_sel_n !== q_dig[0]) begin
          if (mis == 0) begin
            a_seg = seg_out; e_seg = es; a_dig = dig_sel_n; e_dig = q_dig[0];
          end
          mis++;
        end
      end
      idx++;
      if (idx == SLOT) begin
        if (q_seg.size() > 0) begin
          checks++;
          if (mis != 0) begin
            errors++;
            $display("FAIL %s: seg=%02h dig_n=%02h expected seg=%02h dig_n=%02h (%0d bad samples)",
                     q_tag[0], a_seg, a_dig, e_seg, e_dig, mis);
          end
          void'(q_dig.pop_front()); void'(q_seg.pop_front());
          void'(q_on.pop_front());  void'(q_tag.pop_front());
        end
        idx = 0; mis = 0;
        ->slot_done;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < ND; i++) digit_data[i*8 +: 8] = 8'h01 << i;
    decode_mask = '0; intensity = 4'd15; scan_limit = 3'd7;
    shutdown = 1'b0; test_mode = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (seg_out !== 8'h00 || dig_sel_n !== 8'hFF) begin
      errors++;
      $display("FAIL R1: seg=%02h dig_n=%02h expected seg=00 dig_n=FF", seg_out, dig_sel_n);
    end
    rst_n <= 1'b1;
    // R1 R2 R6: first slot is digit 0; raw walking bit per digit
    play(8, "R1 R2 R6 raw walking bit");
    play(8, "R2 R6 wrap");

    // R3: every brightness code on digit 0 only
    for (int i = 0; i < ND; i++) digit_data[i*8 +: 8] = 8'hA5;
    scan_limit = 3'd0;
    for (int k = 0; k < 16; k++) begin
      intensity = 4'(k);
      play(1, "R3 duty");
    end

    // R4 R5: font entries 0..7 then 8..F, DP on alternate digits
    intensity = 4'd9; scan_limit = 3'd7; decode_mask = 8'hFF;
    for (int i = 0; i < ND; i++) digit_data[i*8 +: 8] = {i[0], 3'b101, 4'(i)};
    play(8, "R4 R5 font low");
    for (int i = 0; i < ND; i++) digit_data[i*8 +: 8] = {~i[0], 3'b010, 4'(i + 8)};
    play(8, "R4 R5 font high");

    // R2 R6: mixed mask and shorter scans, limit lowered mid-frame
    decode_mask = 8'h0F;
    for (int i = 0; i < ND; i++) digit_data[i*8 +: 8] = 8'h30 + 8'(i * 17);
    scan_limit = 3'd4;
    play(3, "R2 R6 mixed");
    scan_limit = 3'd1;
    play(5, "R2 limit lowered");
    scan_limit = 3'd2;
    play(6, "R2 limit 2");

    // R7: shutdown then recovery with data intact
    shutdown = 1'b1;
    play(4, "R7 shutdown dark");
    shutdown = 1'b0;
    play(4, "R7 data retained");

    // R8: test overrides shutdown and scan limit, then prior display returns
    shutdown = 1'b1; test_mode = 1'b1; scan_limit = 3'd1;
    play(9, "R8 test over shutdown");
    shutdown = 1'b0; test_mode = 1'b0; intensity = 4'd0;
    play(3, "R8 after test");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule